// File: doc/BRIEF.md
# F-Channel Flow-Control and OAM Slot Scheduler

This block shares the two per-container F-channel bytes (F1 and F2) between two uses: flow-control signalling and a low-rate OAM byte stream. A frame is 56 transport containers long. The first container is marked by a frame-start flag that comes from the cell delineation logic. The block keeps a container counter for each direction. For every container it decides whether F1/F2 belong to the OAM channel or to the flow-control channel. Every seventh container, starting at container 6, belongs to OAM.

On the transmit side, each container strobe loads F1/F2 with one of three things:
- two bytes of the local 31-bit halt request vector;
- the OAM byte pair offered on a valid/ready handshake;
- an all-zero idle pair, when no OAM pair is waiting in an OAM container.

On the receive side, each strobe routes incoming F1/F2 to one of two places. OAM pairs go to a pulsed OAM output. Flow-control bytes update a held 31-bit halt vector that the local transmitter obeys. When all 31 halt bits are set, the block raises a global halt. Loss of frame alignment forces every port into halt until fresh send bits arrive.

Top module: `fchan_sched`

## Requirements
- R1: A strobe that comes with its frame-start flag is container 0. Each later strobe without the flag is the next container, and the index wraps from 55 to 0. Transmit and receive count independently.
- R2: Container k is an OAM container exactly when k >= 6 and (k - 6) is a multiple of 7. The OAM containers are 6, 13, 20, 27, 34, 41, 48 and 55.
- R3: In an even, non-OAM transmit container, F1 carries halt-request bits 7..0 and F2 carries bits 15..8. Port p sits at bit p mod 8, and 1 means halt.
- R4: In an odd, non-OAM transmit container, F1 carries request bits 23..16. F2 bits 6..0 carry request bits 30..24, and F2 bit 7 is sent as 0.
- R5: oam_tx_ready is high during the strobe cycle of every transmit OAM container and only then. In that container F1/F2 carry oam_tx_b1/oam_tx_b2 if oam_tx_valid is high, and 0x00/0x00 otherwise.
- R6: tx_f1/tx_f2 change in the cycle after a transmit strobe and hold their value until the next strobe.
- R7: A receive strobe in an even, non-OAM container loads rx_halt[15:0] from {F2,F1}. In an odd, non-OAM container it loads rx_halt[30:16] from {F2[6:0],F1}, and F2 bit 7 is ignored. The new value appears in the next cycle.
- R8: A receive OAM container whose pair is not all zero produces a one-cycle oam_rx_valid pulse in the next cycle, with the bytes on oam_rx_b1/oam_rx_b2. The halt vector does not change in that container.
- R9: A receive OAM container whose pair is 0x00/0x00 produces no oam_rx_valid pulse.
- R10: rx_global_halt is high exactly when all 31 rx_halt bits are set.
- R11: Reset, and rx_align_lost in any cycle, set every rx_halt bit to 1 in the next cycle. If a strobe comes in the same cycle, its flow-control bytes are discarded.
- R12: rx_f1/rx_f2 have no effect on rx_halt or oam_rx_valid in cycles without a receive strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_tc_strobe | input | 1 | One-cycle pulse per transmit container |
| tx_frame_start | input | 1 | With tx_tc_strobe: this container is container 0 |
| fc_tx_halt | input | 31 | Halt request per remote port to be signalled |
| oam_tx_valid | input | 1 | An OAM byte pair is waiting |
| oam_tx_b1 | input | 8 | OAM byte for F1 |
| oam_tx_b2 | input | 8 | OAM byte for F2 |
| oam_tx_ready | output | 1 | OAM pair taken in this cycle |
| tx_f1 | output | 8 | F1 byte for the current transmit container |
| tx_f2 | output | 8 | F2 byte for the current transmit container |
| rx_tc_strobe | input | 1 | One-cycle pulse per received container |
| rx_frame_start | input | 1 | With rx_tc_strobe: this container is container 0 |
| rx_align_lost | input | 1 | Frame alignment lost; forces all-halt |
| rx_f1 | input | 8 | Received F1 byte |
| rx_f2 | input | 8 | Received F2 byte |
| oam_rx_valid | output | 1 | One-cycle pulse: received OAM pair |
| oam_rx_b1 | output | 8 | Received OAM byte from F1 |
| oam_rx_b2 | output | 8 | Received OAM byte from F2 |
| rx_halt | output | 31 | Held halt state per local port, 1 = halt |
| rx_global_halt | output | 1 | All ports halted |

## Verification
A full directed frame starting at a frame-start strobe walks every container index. This shows whether the slot classification and the even/odd byte assignment follow the index, and whether the wrap lands on 0. A second frame start in mid-frame shows that the flag overrides the running count. Directed receive pairs of all ones, with and without F2 bit 7, separate a true global halt from one that wrongly depends on the reserved bit. A following cleared bit shows that the global halt releases. Random traffic mixes zero pairs, all-ones pairs, random bytes, alignment losses and idle gaps carrying changing F-bytes. This tells apart OAM routing, idle suppression, halt holding between strobes and forced all-halt.

// File: rtl/fchan_pkg.sv
package fchan_pkg;
   localparam int FB_W   = 8;          // width of one F-channel byte
   localparam int FC_W   = 4 * FB_W;   // four flow-control bytes per vector
   localparam logic [FB_W-1:0] IDLE_BYTE = '0;
endpackage

// File: rtl/fchan_tc_counter.sv
module fchan_tc_counter #(
   parameter int NUM_TC     = 56,
   parameter int OAM_FIRST  = 6,
   parameter int OAM_STRIDE = 7,
   parameter int IDX_W      = $clog2(NUM_TC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic frame_start,
   output logic cur_oam,
   output logic cur_odd
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TC - 1);

   logic [IDX_W-1:0]  next_q;
   logic [IDX_W-1:0]  cur_idx;
   logic [NUM_TC-1:0] oam_mask;

   for (genvar g = 0; g < NUM_TC; g++) begin : g_mask
      assign oam_mask[g] = (g >= OAM_FIRST) && (((g - OAM_FIRST) % OAM_STRIDE) == 0);
   end

   assign cur_idx = frame_start ? '0 : next_q;
   assign cur_oam = oam_mask[cur_idx];
   assign cur_odd = cur_idx[0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         next_q <= '0;
      else if (strobe)
         next_q <= (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
   end

   assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      next_q <= LAST_IDX);
   assert_fs_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && frame_start) |=> (next_q == IDX_W'(1)));
endmodule

// File: rtl/fchan_tx_mux.sv
module fchan_tx_mux
   import fchan_pkg::*;
#(
   parameter int NUM_PORTS = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strobe,
   input  logic                 slot_oam,
   input  logic                 slot_odd,
   input  logic [NUM_PORTS-1:0] fc_halt,
   input  logic                 oam_valid,
   input  logic [FB_W-1:0]      oam_b1,
   input  logic [FB_W-1:0]      oam_b2,
   output logic                 oam_ready,
   output logic [FB_W-1:0]      f1,
   output logic [FB_W-1:0]      f2
);
   logic [FC_W-1:0] fc_word;     // unused upper bits, incl. reserved, are zero
   logic [FB_W-1:0] f1_d, f2_d;

   assign fc_word   = FC_W'(fc_halt);
   assign oam_ready = strobe && slot_oam;

   always_comb begin
      if (slot_oam) begin
         f1_d = oam_valid ? oam_b1 : IDLE_BYTE;
         f2_d = oam_valid ? oam_b2 : IDLE_BYTE;
      end else if (slot_odd) begin
         f1_d = fc_word[2*FB_W +: FB_W];
         f2_d = fc_word[3*FB_W +: FB_W];
      end else begin
         f1_d = fc_word[0 +: FB_W];
         f2_d = fc_word[FB_W +: FB_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f1 <= '0;
         f2 <= '0;
      end else if (strobe) begin
         f1 <= f1_d;
         f2 <= f2_d;
      end
   end

   assert_oam_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && slot_oam && !oam_valid) |=> (f1 == IDLE_BYTE && f2 == IDLE_BYTE));
   assert_fc_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !slot_oam && slot_odd) |=> (f2[FB_W-1] == 1'b0));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> ($stable(f1) && $stable(f2)));
endmodule

// File: rtl/fchan_rx_steer.sv
module fchan_rx_steer
   import fchan_pkg::*;
#(
   parameter int NUM_PORTS = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strobe,
   input  logic                 slot_oam,
   input  logic                 slot_odd,
   input  logic                 align_lost,
   input  logic [FB_W-1:0]      f1,
   input  logic [FB_W-1:0]      f2,
   output logic                 oam_valid,
   output logic [FB_W-1:0]      oam_b1,
   output logic [FB_W-1:0]      oam_b2,
   output logic [NUM_PORTS-1:0] halt,
   output logic                 global_halt
);
   logic [FC_W-1:0]      word;
   logic [NUM_PORTS-1:0] halt_d;
   logic                 oam_take;
   logic                 rsv_unused;

   always_comb begin
      word = FC_W'(halt);
      if (slot_odd) word[2*FB_W +: 2*FB_W] = {f2, f1};
      else          word[0 +: 2*FB_W]      = {f2, f1};
   end
   assign halt_d     = word[NUM_PORTS-1:0];
   assign rsv_unused = word[FC_W-1];
   assign oam_take   = strobe && slot_oam && ({f1, f2} != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || align_lost)
         halt <= '1;
      else if (strobe && !slot_oam)
         halt <= halt_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oam_valid <= 1'b0;
         oam_b1    <= '0;
         oam_b2    <= '0;
      end else begin
         oam_valid <= oam_take;
         if (oam_take) begin
            oam_b1 <= f1;
            oam_b2 <= f2;
         end
      end
   end

   assign global_halt = &halt;

   assert_realign_R11: assert property (@(posedge clk) disable iff (!rst_n)
      align_lost |=> (&halt));
   assert_oam_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && slot_oam && !align_lost) |=> $stable(halt));
   assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && slot_oam && f1 == '0 && f2 == '0) |=> !oam_valid);
   assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !align_lost) |=> ($stable(halt) && !oam_valid));
endmodule

// File: rtl/fchan_sched.sv
module fchan_sched
   import fchan_pkg::*;
#(
   parameter int NUM_TC     = 56,
   parameter int OAM_FIRST  = 6,
   parameter int OAM_STRIDE = 7,
   parameter int NUM_PORTS  = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_tc_strobe,
   input  logic                 tx_frame_start,
   input  logic [NUM_PORTS-1:0] fc_tx_halt,
   input  logic                 oam_tx_valid,
   input  logic [FB_W-1:0]      oam_tx_b1,
   input  logic [FB_W-1:0]      oam_tx_b2,
   output logic                 oam_tx_ready,
   output logic [FB_W-1:0]      tx_f1,
   output logic [FB_W-1:0]      tx_f2,
   input  logic                 rx_tc_strobe,
   input  logic                 rx_frame_start,
   input  logic                 rx_align_lost,
   input  logic [FB_W-1:0]      rx_f1,
   input  logic [FB_W-1:0]      rx_f2,
   output logic                 oam_rx_valid,
   output logic [FB_W-1:0]      oam_rx_b1,
   output logic [FB_W-1:0]      oam_rx_b2,
   output logic [NUM_PORTS-1:0] rx_halt,
   output logic                 rx_global_halt
);
   localparam int IDX_W = $clog2(NUM_TC);

   initial begin
      assert (NUM_TC >= 2) else $fatal(1, "NUM_TC too small");
      assert (OAM_STRIDE >= 1) else $fatal(1, "OAM_STRIDE must be positive");
      assert (OAM_FIRST >= 0 && OAM_FIRST < NUM_TC) else $fatal(1, "OAM_FIRST out of frame");
      assert (NUM_PORTS > 2*FB_W && NUM_PORTS < FC_W) else $fatal(1, "NUM_PORTS out of range");
   end

   logic tx_oam, tx_odd, rx_oam, rx_odd;

   fchan_tc_counter #(.NUM_TC(NUM_TC), .OAM_FIRST(OAM_FIRST),
                      .OAM_STRIDE(OAM_STRIDE), .IDX_W(IDX_W)) u_tx_cnt (
      .clk(clk), .rst_n(rst_n), .strobe(tx_tc_strobe), .frame_start(tx_frame_start),
      .cur_oam(tx_oam), .cur_odd(tx_odd));

   fchan_tc_counter #(.NUM_TC(NUM_TC), .OAM_FIRST(OAM_FIRST),
                      .OAM_STRIDE(OAM_STRIDE), .IDX_W(IDX_W)) u_rx_cnt (
      .clk(clk), .rst_n(rst_n), .strobe(rx_tc_strobe), .frame_start(rx_frame_start),
      .cur_oam(rx_oam), .cur_odd(rx_odd));

   fchan_tx_mux #(.NUM_PORTS(NUM_PORTS)) u_tx (
      .clk(clk), .rst_n(rst_n), .strobe(tx_tc_strobe), .slot_oam(tx_oam),
      .slot_odd(tx_odd), .fc_halt(fc_tx_halt), .oam_valid(oam_tx_valid),
      .oam_b1(oam_tx_b1), .oam_b2(oam_tx_b2), .oam_ready(oam_tx_ready),
      .f1(tx_f1), .f2(tx_f2));

   fchan_rx_steer #(.NUM_PORTS(NUM_PORTS)) u_rx (
      .clk(clk), .rst_n(rst_n), .strobe(rx_tc_strobe), .slot_oam(rx_oam),
      .slot_odd(rx_odd), .align_lost(rx_align_lost), .f1(rx_f1), .f2(rx_f2),
      .oam_valid(oam_rx_valid), .oam_b1(oam_rx_b1), .oam_b2(oam_rx_b2),
      .halt(rx_halt), .global_halt(rx_global_halt));

   assert_ready_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      oam_tx_ready |-> tx_tc_strobe);
   assert_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_align_lost |=> rx_global_halt);
endmodule

// File: tb/fchan_sched_test.sv
`timescale 1ns/1ps
module fchan_sched_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tx_tc_strobe, tx_frame_start, oam_tx_valid, oam_tx_ready;
   logic [30:0] fc_tx_halt;
   logic [7:0]  oam_tx_b1, oam_tx_b2, tx_f1, tx_f2;
   logic        rx_tc_strobe, rx_frame_start, rx_align_lost, oam_rx_valid, rx_global_halt;
   logic [7:0]  rx_f1, rx_f2, oam_rx_b1, oam_rx_b2;
   logic [30:0] rx_halt;

   always #5 clk = ~clk;

   fchan_sched uut (
      .clk(clk), .rst_n(rst_n), .tx_tc_strobe(tx_tc_strobe), .tx_frame_start(tx_frame_start),
      .fc_tx_halt(fc_tx_halt), .oam_tx_valid(oam_tx_valid), .oam_tx_b1(oam_tx_b1),
      .oam_tx_b2(oam_tx_b2), .oam_tx_ready(oam_tx_ready), .tx_f1(tx_f1), .tx_f2(tx_f2),
      .rx_tc_strobe(rx_tc_strobe), .rx_frame_start(rx_frame_start),
      .rx_align_lost(rx_align_lost), .rx_f1(rx_f1), .rx_f2(rx_f2),
      .oam_rx_valid(oam_rx_valid), .oam_rx_b1(oam_rx_b1), .oam_rx_b2(oam_rx_b2),
      .rx_halt(rx_halt), .rx_global_halt(rx_global_halt));

   int          vectors = 0;
   int          errors  = 0;
   bit          done    = 0;
   int          tx_idx_m = 0;
   int          rx_idx_m = 0;
   logic [30:0] halt_m  = '1;
   logic [15:0] last_tx = '0;

   function automatic bit is_oam(int i);
      return (i >= 6) && (((i - 6) % 7) == 0);
   endfunction

   function automatic logic [15:0] tx_model(int i, logic [30:0] fc, bit v,
                                            logic [7:0] b1, logic [7:0] b2);
      if (is_oam(i)) return v ? {b1, b2} : 16'h0000;
      if (i % 2 == 0) return {fc[7:0], fc[15:8]};
      return {fc[23:16], 1'b0, fc[30:24]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic container(bit tfs, bit rfs, logic [30:0] fc, bit ov,
                            logic [7:0] ob1, logic [7:0] ob2,
                            logic [7:0] r1, logic [7:0] r2, bit lost);
      int ti, ri;
      logic [15:0] tx_exp;
      bit ov_exp;
      string ttag;
      @(negedge clk);
      tx_tc_strobe = 1; tx_frame_start = tfs; fc_tx_halt = fc;
      oam_tx_valid = ov; oam_tx_b1 = ob1; oam_tx_b2 = ob2;
      rx_tc_strobe = 1; rx_frame_start = rfs; rx_f1 = r1; rx_f2 = r2; rx_align_lost = lost;
      ti = tfs ? 0 : tx_idx_m;
      ri = rfs ? 0 : rx_idx_m;
      #1 check("R1 R2 ready", 32'(oam_tx_ready), 32'(is_oam(ti)));
      tx_exp = tx_model(ti, fc, ov, ob1, ob2);
      ttag = is_oam(ti) ? "R5 oam pair" : ((ti % 2 == 0) ? "R3 even fc" : "R4 odd fc");
      if (lost) halt_m = '1;
      else if (!is_oam(ri)) begin
         if (ri % 2 == 0) halt_m[15:0]  = {r2, r1};
         else             halt_m[30:16] = {r2[6:0], r1};
      end
      ov_exp = is_oam(ri) && ({r1, r2} != 16'h0);
      @(negedge clk);
      tx_tc_strobe = 0; tx_frame_start = 0; oam_tx_valid = 0;
      rx_tc_strobe = 0; rx_frame_start = 0; rx_align_lost = 0;
      check(ttag, 32'({tx_f1, tx_f2}), 32'(tx_exp));
      check("R8 R9 oam valid", 32'(oam_rx_valid), 32'(ov_exp));
      if (ov_exp) check("R8 oam bytes", 32'({oam_rx_b1, oam_rx_b2}), 32'({r1, r2}));
      check(lost ? "R11 realign" : "R7 halt", 32'(rx_halt), 32'(halt_m));
      check("R10 global", 32'(rx_global_halt), 32'(&halt_m));
      last_tx  = tx_exp;
      tx_idx_m = (ti == 55) ? 0 : ti + 1;
      rx_idx_m = (ri == 55) ? 0 : ri + 1;
   endtask

   task automatic gap(int n);
      for (int k = 0; k < n; k++) begin
         rx_f1 = 8'($urandom); rx_f2 = 8'($urandom);
         @(negedge clk);
         check("R12 quiet halt", 32'(rx_halt), 32'(halt_m));
         check("R12 quiet oam", 32'(oam_rx_valid), 32'h0);
         check("R6 tx hold", 32'({tx_f1, tx_f2}), 32'(last_tx));
      end
   endtask

   function automatic logic [7:0] rx_byte(int sel);
      case (sel)
         0: return 8'h00;
         1: return 8'hFF;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1977));
      rst_n = 0;
      tx_tc_strobe = 0; tx_frame_start = 0; fc_tx_halt = '0; oam_tx_valid = 0;
      oam_tx_b1 = '0; oam_tx_b2 = '0; rx_tc_strobe = 0; rx_frame_start = 0;
      rx_align_lost = 0; rx_f1 = '0; rx_f2 = '0;
      repeat (3) @(negedge clk);
      check("R11 reset halt", 32'(rx_halt), 32'h7FFF_FFFF);
      check("R10 reset global", 32'(rx_global_halt), 32'h1);
      check("R6 reset tx", 32'({tx_f1, tx_f2}), 32'h0);
      check("R8 reset oam", 32'(oam_rx_valid), 32'h0);
      rst_n = 1;

      // Full frame from a frame start, then the wrap into the next frame (R1, R2)
      for (int i = 0; i < 60; i++)
         container(i == 0, i == 0, 31'($urandom), i % 3 != 0, 8'(i + 1), 8'($urandom),
                   8'($urandom), (i % 4 == 0) ? 8'h00 : 8'($urandom), 1'b0);

      // Mid-frame restart (R1)
      container(1'b1, 1'b1, 31'h1234_5678, 1'b0, 8'h0, 8'h0, 8'h11, 8'h22, 1'b0);
      container(1'b0, 1'b0, 31'h7654_3210, 1'b0, 8'h0, 8'h0, 8'h33, 8'h44, 1'b0);

      // Global halt corners: all-ones, reserved bit ignored, release (R7, R10)
      container(1'b1, 1'b1, '0, 1'b0, 8'h0, 8'h0, 8'hFF, 8'hFF, 1'b0);
      container(1'b0, 1'b0, '0, 1'b0, 8'h0, 8'h0, 8'hFF, 8'h7F, 1'b0);
      container(1'b0, 1'b0, '0, 1'b0, 8'h0, 8'h0, 8'hFF, 8'hFF, 1'b0);
      container(1'b0, 1'b0, '0, 1'b0, 8'h0, 8'h0, 8'hFF, 8'h7F, 1'b0);
      container(1'b0, 1'b0, '0, 1'b0, 8'h0, 8'h0, 8'hFE, 8'hFF, 1'b0);
      container(1'b0, 1'b0, '0, 1'b0, 8'h0, 8'h0, 8'h00, 8'h00, 1'b0);
      // OAM container 6: idle pair dropped, then OAM hold of halt (R8, R9, R5)
      container(1'b0, 1'b0, 31'h7FFF_FFFF, 1'b0, 8'hAA, 8'h55, 8'h00, 8'h00, 1'b0);
      gap(2);
      // Alignment loss with a strobe in the same cycle (R11)
      container(1'b0, 1'b0, '0, 1'b0, 8'h0, 8'h0, 8'h00, 8'h00, 1'b1);
      gap(1);

      // Constrained random traffic
      for (int n = 0; n < 500; n++) begin
         container(($urandom % 60) == 0, ($urandom % 60) == 0, 31'($urandom),
                   1'($urandom), 8'($urandom), 8'($urandom),
                   rx_byte(int'($urandom % 4)), rx_byte(int'($urandom % 4)),
                   ($urandom % 50) == 0);
         gap(int'($urandom % 3));
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule